// File: doc/BRIEF.md
# Multiplexed Display Grid Scan Timer

This block is the master-side timing engine for a multiplexed fluorescent display. It divides the system clock into bit times and walks through two or three grid slots of equal length. While a slot is active it lights that slot's grid and places the segment pattern for that grid on a 56-bit segment bus. A duplex/triplex select input sets how many grids take part in the scan.

Brightness comes from a 10-bit dimming value. Inside each slot the grid is lit for as many bit times as the value says. The segment bus stays on for three bit times after the grid turns off. The value is capped so that every slot ends with a dark gap. A dimming pulse output and a two-bit grid code are both active during the segment window, so a second display unit can follow this one.

The scan is held in a three-state machine, with one state per grid: `GS_G1`, `GS_G2` and `GS_G3`. The state can change only when a slot ends. The transitions are: `GS_G1 -> GS_G2` always. `GS_G2 -> GS_G3` in triplex and `GS_G2 -> GS_G1` in duplex. `GS_G3 -> GS_G1` always. Reset enters `GS_G1`.

Top module: `vfd_grid_scan`

## Requirements
- R1: After reset the scan is in the grid-1 slot at bit time 0. Every output is low, and the effective dimming value is 0 until the first slot boundary, so the first slot stays dark.
- R2: One bit time is 4 clock cycles and each grid slot lasts 1024 bit times (4096 clocks).
- R3: With `dup_sel` high the slots run grid 1, grid 2, grid 1, and so on, and grid 3 is never used. With `dup_sel` low they run grid 1, grid 2, grid 3. `dup_sel` is read at the end of each slot.
- R4: `grid_en` bit 0, 1 or 2 (grid 1, 2 or 3) is high only for the active slot's grid, during the first D bit times of that slot. It is low for the rest of the slot, and at most one bit is ever high.
- R5: Dimming values 1016 through 1023 act as 1016. A value of 0 leaves the grid dark for the whole slot.
- R6: For D > 0 the segment window is open for the first D+3 bit times of the slot, and it is closed when D = 0. `dim_out` is high exactly while the window is open, so it stays high for 3 bit times after the grid enable falls.
- R7: While the window is open, `seg_out` equals the latch input of the active grid (`lat_g1`, `lat_g2` or `lat_g3`). Outside the window it is all zeros.
- R8: The dimming input is captured only at a slot boundary. A change made part-way through a slot has no effect until the next slot begins.
- R9: While the window is open, (`sync1_out`, `sync2_out`) is (1,0) for grid 1, (0,1) for grid 2 and (1,1) for grid 3. Outside the window it is (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dup_sel | input | 1 | High selects two-grid scan, low selects three-grid scan |
| dim_val | input | 10 | Dimming value, on-time in bit times per slot |
| lat_g1 | input | 56 | Segment pattern for grid 1 |
| lat_g2 | input | 56 | Segment pattern for grid 2 |
| lat_g3 | input | 56 | Segment pattern for grid 3 |
| grid_en | output | 3 | One-hot grid enables, bit 0 is grid 1 |
| seg_out | output | 56 | Gated segment bus |
| dim_out | output | 1 | Segment window pulse for a follower unit |
| sync1_out | output | 1 | Grid code, first bit |
| sync2_out | output | 1 | Grid code, second bit |

## Verification
The assertions check the fixed relations on every cycle. The grid enables are never more than one-hot. A lit grid always lies inside the segment window, and the window outlives the grid when the grid drops. Segments and the sync code are quiet outside the window, and runs of grid-on and window-on never exceed the capped duty. Only the bench scenarios can show which grid is chosen and for how long: the slot order in each mode, the exact on-lengths for values of 0, 64, 1016 and 1023, which latch reaches the bus, and that a dimming change part-way through a slot is held off until the boundary.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic [1:0] {
        GS_G1 = 2'd0,
        GS_G2 = 2'd1,
        GS_G3 = 2'd2
    } grid_state_e;

    // Follower code per grid: {first bit, second bit}
    function automatic logic [1:0] grid_code(grid_state_e s);
        logic [1:0] c;
        unique case (s)
            GS_G1:   c = 2'b10;
            GS_G2:   c = 2'b01;
            GS_G3:   c = 2'b11;
            default: c = 2'b00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vfd_bit_tick.sv
module vfd_bit_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                end else if (div_cnt == DIV_W'(TICK_DIV - 1)) begin
                    div_cnt <= '0;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
            assign tick = (div_cnt == DIV_W'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_LEN = 1024,
    parameter int BIT_W    = $clog2(SLOT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             triplex,
    output grid_state_e      state,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             slot_adv
);
    grid_state_e nxt_state;

    assign slot_adv = tick && (bit_cnt == BIT_W'(SLOT_LEN - 1));

    // Next grid, chosen when a slot ends
    always_comb begin
        nxt_state = state;
        unique case (state)
            GS_G1:   nxt_state = GS_G2;
            GS_G2:   nxt_state = triplex ? GS_G3 : GS_G1;
            GS_G3:   nxt_state = GS_G1;
            default: nxt_state = GS_G1;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GS_G1;
        end else if (slot_adv) begin
            state <= nxt_state;
        end
    end

    // Bit-time position within the slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (slot_adv) begin
            bit_cnt <= '0;
        end else if (tick) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vfd_pwm_window.sv
module vfd_pwm_window #(
    parameter int DIM_W   = 10,
    parameter int BIT_W   = 10,
    parameter int DIM_MAX = 1016,
    parameter int SEG_EXT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIM_W-1:0] dim_val,
    input  logic [BIT_W-1:0] bit_cnt,
    output logic             grid_on,
    output logic             seg_on
);
    localparam int WIN_W = ((BIT_W > DIM_W) ? BIT_W : DIM_W) + 2;
    localparam logic [DIM_W-1:0] CAP = DIM_W'(DIM_MAX);

    logic [DIM_W-1:0] dim_eff;
    logic [DIM_W-1:0] dim_lat;
    logic [WIN_W-1:0] pos_x;
    logic [WIN_W-1:0] grid_lim;
    logic [WIN_W-1:0] seg_lim;

    assign dim_eff = (dim_val > CAP) ? CAP : dim_val;

    // Duty is captured only at a slot boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dim_lat <= '0;
        end else if (load) begin
            dim_lat <= dim_eff;
        end
    end

    assign pos_x    = WIN_W'(bit_cnt);
    assign grid_lim = WIN_W'(dim_lat);
    assign seg_lim  = grid_lim + WIN_W'(SEG_EXT);
    assign grid_on  = pos_x < grid_lim;
    assign seg_on   = (dim_lat != '0) && (pos_x < seg_lim);

endmodule

// File: rtl/vfd_grid_scan.sv
module vfd_grid_scan
    import vfd_scan_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int SLOT_LEN = 1024,
    parameter int DIM_W    = 10,
    parameter int DIM_MAX  = 1016,
    parameter int SEG_EXT  = 3,
    parameter int SEG_W    = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dup_sel,
    input  logic [DIM_W-1:0] dim_val,
    input  logic [SEG_W-1:0] lat_g1,
    input  logic [SEG_W-1:0] lat_g2,
    input  logic [SEG_W-1:0] lat_g3,
    output logic [2:0]       grid_en,
    output logic [SEG_W-1:0] seg_out,
    output logic             dim_out,
    output logic             sync1_out,
    output logic             sync2_out
);
    localparam int BIT_W = $clog2(SLOT_LEN);

    logic             tick;
    logic             slot_adv;
    logic [BIT_W-1:0] bit_cnt;
    grid_state_e      state;
    logic             grid_on;
    logic             seg_on;
    logic [1:0]       code;

    vfd_bit_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    vfd_slot_seq #(.SLOT_LEN(SLOT_LEN), .BIT_W(BIT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .triplex  (!dup_sel),
        .state    (state),
        .bit_cnt  (bit_cnt),
        .slot_adv (slot_adv)
    );

    vfd_pwm_window #(
        .DIM_W   (DIM_W),
        .BIT_W   (BIT_W),
        .DIM_MAX (DIM_MAX),
        .SEG_EXT (SEG_EXT)
    ) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slot_adv),
        .dim_val (dim_val),
        .bit_cnt (bit_cnt),
        .grid_on (grid_on),
        .seg_on  (seg_on)
    );

    assign code = grid_code(state);

    // Output decode from the scan state
    always_comb begin
        grid_en   = '0;
        seg_out   = '0;
        dim_out   = seg_on;
        sync1_out = seg_on & code[1];
        sync2_out = seg_on & code[0];
        unique case (state)
            GS_G1: begin
                grid_en[0] = grid_on;
                if (seg_on) seg_out = lat_g1;
            end
            GS_G2: begin
                grid_en[1] = grid_on;
                if (seg_on) seg_out = lat_g2;
            end
            GS_G3: begin
                grid_en[2] = grid_on;
                if (seg_on) seg_out = lat_g3;
            end
            default: begin
                grid_en = '0;
            end
        endcase
    end

endmodule

// File: rtl/vfd_grid_scan_chk.sv
module vfd_grid_scan_chk #(
    parameter int TICK_DIV = 4,
    parameter int DIM_MAX  = 1016,
    parameter int SEG_EXT  = 3,
    parameter int SEG_W    = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       grid_en,
    input logic [SEG_W-1:0] seg_out,
    input logic             dim_out,
    input logic             sync1_out,
    input logic             sync2_out
);
    localparam int GRID_CAP = DIM_MAX * TICK_DIV;
    localparam int WIN_CAP  = (DIM_MAX + SEG_EXT) * TICK_DIV;

    logic [31:0] grid_run;
    logic [31:0] win_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_run <= '0;
            win_run  <= '0;
        end else begin
            grid_run <= (grid_en != '0) ? grid_run + 1 : '0;
            win_run  <= dim_out ? win_run + 1 : '0;
        end
    end

    a_r4_grid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_en));

    a_r6_grid_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_en != '0) |-> dim_out);

    a_r6_window_outlives_grid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grid_en != '0) |-> dim_out);

    a_r7_seg_dark_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !dim_out |-> (seg_out == '0));

    a_r9_sync_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        dim_out |-> (sync1_out || sync2_out));

    a_r9_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dim_out |-> (!sync1_out && !sync2_out));

    a_r5_grid_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
        grid_run <= 32'(GRID_CAP));

    a_r6_window_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
        win_run <= 32'(WIN_CAP));

endmodule

bind vfd_grid_scan vfd_grid_scan_chk #(
    .TICK_DIV (TICK_DIV),
    .DIM_MAX  (DIM_MAX),
    .SEG_EXT  (SEG_EXT),
    .SEG_W    (SEG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grid_en   (grid_en),
    .seg_out   (seg_out),
    .dim_out   (dim_out),
    .sync1_out (sync1_out),
    .sync2_out (sync2_out)
);

// File: tb/vfd_grid_scan_tb.sv
module vfd_grid_scan_tb_top;

    localparam int DIV  = 4;
    localparam int SLOT = 1024;
    localparam int SCLK = DIV * SLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dup_sel = 1'b0;
    logic [9:0]  dim_val = '0;
    logic [55:0] lat_g1 = 56'h00_A5A5_0F0F_1234;
    logic [55:0] lat_g2 = 56'hC3_0000_FFFF_0001;
    logic [55:0] lat_g3 = 56'h81_7E00_5555_AAAA;
    logic [2:0]  grid_en;
    logic [55:0] seg_out;
    logic        dim_out;
    logic        sync1_out;
    logic        sync2_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state
    int m_sub = 0;
    int m_bit = 0;
    int m_g   = 0;
    int m_d   = 0;

    always #2 clk = ~clk;

    vfd_grid_scan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dup_sel   (dup_sel),
        .dim_val   (dim_val),
        .lat_g1    (lat_g1),
        .lat_g2    (lat_g2),
        .lat_g3    (lat_g3),
        .grid_en   (grid_en),
        .seg_out   (seg_out),
        .dim_out   (dim_out),
        .sync1_out (sync1_out),
        .sync2_out (sync2_out)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sub = 0; m_bit = 0; m_g = 0; m_d = 0;
        end else if (m_sub == DIV - 1) begin
            m_sub = 0;
            if (m_bit == SLOT - 1) begin
                m_bit = 0;
                if (m_g == 0) m_g = 1;
                else if (m_g == 1) m_g = dup_sel ? 0 : 2;
                else m_g = 0;
                m_d = (dim_val > 1016) ? 1016 : int'(dim_val);
            end else begin
                m_bit++;
            end
        end else begin
            m_sub++;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit g_on, s_on;
            logic [2:0]  e_grid;
            logic [55:0] e_seg;
            logic [1:0]  e_sync;
            g_on = m_bit < m_d;
            s_on = (m_d != 0) && (m_bit < m_d + 3);
            e_grid = g_on ? (3'b001 << m_g) : 3'b000;
            e_seg  = !s_on ? '0 : (m_g == 0) ? lat_g1 : (m_g == 1) ? lat_g2 : lat_g3;
            e_sync = !s_on ? 2'b00 : (m_g == 0) ? 2'b10 : (m_g == 1) ? 2'b01 : 2'b11;
            check("R2 R3 R4 grid_en", grid_en, e_grid);
            check("R6 dim_out", dim_out, s_on);
            check("R7 seg_out", seg_out, e_seg);
            check("R9 sync", {sync1_out, sync2_out}, e_sync);
        end
    end

    task automatic wait_slot_start();
        do @(negedge clk); while (!(m_sub == 0 && m_bit == 0));
    endtask

    // Count lit cycles over one slot starting at the current negedge
    task automatic measure_slot(string req, int exp_grid, int exp_win,
                                bit mid_change, logic [9:0] mid_val);
        int n_grid = 0;
        int n_win  = 0;
        for (int i = 0; i < SCLK; i++) begin
            if (grid_en != 0) n_grid++;
            if (dim_out) n_win++;
            if (mid_change && i == 2000) dim_val = mid_val;
            @(negedge clk);
        end
        check({req, " grid on-cycles"}, n_grid, exp_grid);
        check({req, " window on-cycles"}, n_win, exp_win);
    endtask

    task automatic count_grid(string req, int idx, int slots, int exp);
        int n = 0;
        for (int i = 0; i < slots * SCLK; i++) begin
            if (grid_en[idx]) n++;
            @(negedge clk);
        end
        check(req, n, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 reset grid_en", grid_en, 0);
        check("R1 reset seg_out", seg_out, 0);
        check("R1 reset dim/sync", {dim_out, sync1_out, sync2_out}, 0);
        rst_n = 1'b1;
        dim_val = 10'd1016;
        // R1: first slot dark even though dim_val is non-zero
        measure_slot("R1", 0, 0, 1'b0, '0);
        // R4 R6: full duty, triplex grid 2 slot
        measure_slot("R4 R6 D=1016", 1016 * DIV, 1019 * DIV, 1'b0, '0);
        dim_val = 10'd1023;
        wait_slot_start();
        measure_slot("R5 clamp 1023", 1016 * DIV, 1019 * DIV, 1'b0, '0);
        dim_val = 10'd64;
        wait_slot_start();
        measure_slot("R4 R6 D=64", 64 * DIV, 67 * DIV, 1'b0, '0);
        dim_val = 10'd0;
        wait_slot_start();
        measure_slot("R5 D=0", 0, 0, 1'b0, '0);
        dim_val = 10'd200;
        wait_slot_start();
        measure_slot("R8 mid-slot change", 200 * DIV, 203 * DIV, 1'b1, 10'd900);
        // The change applies from the following slot
        measure_slot("R8 next slot", 900 * DIV, 903 * DIV, 1'b0, '0);
        // Duplex: grid 3 never used
        dup_sel = 1'b1;
        dim_val = 10'd100;
        wait_slot_start();
        count_grid("R3 duplex grid3 idle", 2, 4, 0);
        wait_slot_start();
        count_grid("R3 duplex grid1 use", 0, 4, 2 * 100 * DIV);
        dup_sel = 1'b0;
        wait_slot_start();
        wait_slot_start();
        count_grid("R3 triplex grid3 use", 2, 3, 100 * DIV);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule